// File: doc/BRIEF.md
# Exception Entry Sequencer with Banked Registers

This block performs the entry step for exceptions, traps and external interrupts in a small 32-bit CPU. In one clock edge it picks a single event and loads the new program counter. It saves the interrupted PC, status word and stack register, updates the status word, and records the event code. It owns sixteen general registers plus an alternate set of eight that shadows registers 0 to 7. The active set is chosen by the register-bank bit of the status word, and the two sets trade contents whenever that bit changes.

The pipeline presents the current PC, the vector base and a delay-slot flag, and raises at most one request type per cycle. The block answers on the next cycle with a one-cycle redirect pulse and the target PC. A direct status write port lets software change the status word. A plain register write port and two read ports let the datapath use the register sets.

Top module: `exc_entry_ctrl`

## Requirements
- R1: On an accepted event the cycle after the request shows `redirect_valid_o`=1 for one cycle, with `redirect_pc_o` = `vbr_i` + 0x100 for a general exception, trap or illegal instruction, + 0x400 for a TLB miss (`exc_tlb_i`=1), and + 0x600 for an interrupt.
- R2: On entry the saved-PC register takes `pc_i`, the saved-status register takes the status word held before the event, and the saved-stack register takes general register 15.
- R3: On entry the new status word is the old one with bit 30 (privileged), bit 29 (register bank) and bit 28 (event block) set to 1.
- R4: When the bank bit (29) changes, by entry or by a direct status write, registers 0 to 7 and the eight alternate registers swap contents in that same edge. A status write that leaves bit 29 unchanged does not swap. A register write is dropped in any cycle that carries an accepted event or a status write.
- R5: A general, TLB, trap or illegal event raised with `in_slot_i`=1 saves `pc_i`-2 and pulses `slot_clr_o`. An interrupt never adjusts the saved PC.
- R6: Exceptions write their code into `exc_event_o` and leave `irq_event_o` unchanged. Interrupts write their code into `irq_event_o` and leave `exc_event_o` unchanged.
- R7: A trap sets `trap_val_o` to its 8-bit immediate shifted left by 2 and enters as a general exception with event code 0x160.
- R8: An illegal-instruction request records code 0x1A0 when `in_slot_i`=1 and 0x180 otherwise.
- R9: An exception, trap or illegal request while `vbr_i` is zero sets `halt_o`. The halt is sticky until reset, and from that cycle on no status, save, event or register state changes.
- R10: When several requests arrive together, priority is exception, then trap, then illegal, then interrupt. An interrupt request is ignored while status bit 28 is 1.
- R11: Reset gives status 0x700000F0, all registers and event fields zero, and no halt or redirect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_i | input | 32 | PC of the current instruction |
| vbr_i | input | 32 | Vector base |
| in_slot_i | input | 1 | Current instruction is in a branch delay slot |
| exc_req_i | input | 1 | Exception request |
| exc_tlb_i | input | 1 | Exception is a TLB miss |
| exc_code_i | input | 12 | Exception event code |
| trap_req_i | input | 1 | Trap request |
| trap_imm_i | input | 8 | Trap immediate |
| ill_req_i | input | 1 | Illegal-instruction request |
| irq_req_i | input | 1 | External interrupt request |
| irq_code_i | input | 12 | Interrupt event code |
| sr_wr_i | input | 1 | Direct status write strobe |
| sr_wdata_i | input | 32 | Direct status write value |
| reg_we_i | input | 1 | Register write strobe |
| reg_waddr_i | input | 4 | Register write index |
| reg_wdata_i | input | 32 | Register write value |
| reg_raddr_i | input | 4 | Register read index |
| reg_rdata_o | output | 32 | Register read value |
| alt_raddr_i | input | 3 | Alternate register read index |
| alt_rdata_o | output | 32 | Alternate register read value |
| sr_o | output | 32 | Status word |
| saved_pc_o | output | 32 | Saved PC |
| saved_sr_o | output | 32 | Saved status |
| saved_sp_o | output | 32 | Saved register 15 |
| exc_event_o | output | 12 | Exception event code |
| irq_event_o | output | 12 | Interrupt event code |
| trap_val_o | output | 10 | Trap immediate times four |
| halt_o | output | 1 | Halted on unset vector base |
| redirect_valid_o | output | 1 | New PC valid pulse |
| redirect_pc_o | output | 32 | New PC |
| slot_clr_o | output | 1 | Delay-slot flag clear pulse |

## Verification
The hardest cases to reach are those where the bank swap must be seen, because the alternate registers cannot be written directly. The stimulus first fills registers 0 to 15 with distinct values, then flips the bank bit with a status write so those values move into the alternate set. It then checks both read ports after each later entry or status write, including a write that keeps the bit unchanged. The blocked-interrupt case and the halt freeze are each reached by ordering: an interrupt is raised right after an entry has set the block bit, and the halt is tested last, after a zero vector base.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
    localparam int CODE_W = 12;

    typedef enum logic [1:0] {VEC_GEN, VEC_TLB, VEC_IRQ} vec_class_e;

    typedef struct packed {
        logic              valid;
        vec_class_e        cls;
        logic [CODE_W-1:0] code;
        logic              is_trap;
        logic              slot_adj;
    } event_t;
endpackage

// File: rtl/exc_select.sv
module exc_select
    import exc_entry_pkg::*;
#(
    parameter logic [CODE_W-1:0] TRAP_CODE     = 12'h160,
    parameter logic [CODE_W-1:0] ILL_CODE      = 12'h180,
    parameter logic [CODE_W-1:0] SLOT_ILL_CODE = 12'h1A0
) (
    input  logic              exc_req,
    input  logic              exc_tlb,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              trap_req,
    input  logic              ill_req,
    input  logic              irq_req,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              in_slot,
    input  logic              blocked,
    output event_t            ev
);
    always_comb begin
        ev     = '0;
        ev.cls = VEC_GEN;
        if (exc_req) begin
            ev.valid    = 1'b1;
            ev.cls      = exc_tlb ? VEC_TLB : VEC_GEN;
            ev.code     = exc_code;
            ev.slot_adj = in_slot;
        end else if (trap_req) begin
            ev.valid    = 1'b1;
            ev.code     = TRAP_CODE;
            ev.is_trap  = 1'b1;
            ev.slot_adj = in_slot;
        end else if (ill_req) begin
            ev.valid    = 1'b1;
            ev.code     = in_slot ? SLOT_ILL_CODE : ILL_CODE;
            ev.slot_adj = in_slot;
        end else if (irq_req && !blocked) begin
            ev.valid = 1'b1;
            ev.cls   = VEC_IRQ;
            ev.code  = irq_code;
        end
    end
endmodule

// File: rtl/exc_bank_regs.sv
module exc_bank_regs #(
    parameter int DATA_W   = 32,
    parameter int NUM_REGS = 16,
    parameter int NUM_ALT  = 8,
    localparam int AW = $clog2(NUM_REGS),
    localparam int BW = $clog2(NUM_ALT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              swap,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata,
    input  logic [BW-1:0]     braddr,
    output logic [DATA_W-1:0] bdata,
    output logic [DATA_W-1:0] top_reg
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] main;
        logic [NUM_ALT-1:0][DATA_W-1:0]  alt;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (swap) begin
            for (int i = 0; i < NUM_ALT; i++) begin
                st_d.main[i] = st_q.alt[i];
                st_d.alt[i]  = st_q.main[i];
            end
        end else if (we) begin
            st_d.main[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata   = st_q.main[raddr];
    assign bdata   = st_q.alt[braddr];
    assign top_reg = st_q.main[NUM_REGS-1];

    for (genvar g = 0; g < NUM_ALT; g++) begin : g_swap_chk
        // R4
        swap_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
            swap |=> (st_q.main[g] == $past(st_q.alt[g])) && (st_q.alt[g] == $past(st_q.main[g])));
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_entry_pkg::*;
#(
    parameter int          DATA_W   = 32,
    parameter int          NUM_REGS = 16,
    parameter int          NUM_ALT  = 8,
    parameter int          IMM_W    = 8,
    parameter int          MD_BIT   = 30,
    parameter int          RB_BIT   = 29,
    parameter int          BL_BIT   = 28,
    parameter logic [31:0] SR_RESET = 32'h7000_00F0,
    parameter logic [31:0] GEN_OFF  = 32'h100,
    parameter logic [31:0] TLB_OFF  = 32'h400,
    parameter logic [31:0] IRQ_OFF  = 32'h600,
    localparam int AW     = $clog2(NUM_REGS),
    localparam int BW     = $clog2(NUM_ALT),
    localparam int TRAP_W = IMM_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       pc_i,
    input  logic [31:0]       vbr_i,
    input  logic              in_slot_i,
    input  logic              exc_req_i,
    input  logic              exc_tlb_i,
    input  logic [11:0]       exc_code_i,
    input  logic              trap_req_i,
    input  logic [IMM_W-1:0]  trap_imm_i,
    input  logic              ill_req_i,
    input  logic              irq_req_i,
    input  logic [11:0]       irq_code_i,
    input  logic              sr_wr_i,
    input  logic [31:0]       sr_wdata_i,
    input  logic              reg_we_i,
    input  logic [AW-1:0]     reg_waddr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    input  logic [AW-1:0]     reg_raddr_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [BW-1:0]     alt_raddr_i,
    output logic [DATA_W-1:0] alt_rdata_o,
    output logic [31:0]       sr_o,
    output logic [31:0]       saved_pc_o,
    output logic [31:0]       saved_sr_o,
    output logic [DATA_W-1:0] saved_sp_o,
    output logic [11:0]       exc_event_o,
    output logic [11:0]       irq_event_o,
    output logic [TRAP_W-1:0] trap_val_o,
    output logic              halt_o,
    output logic              redirect_valid_o,
    output logic [31:0]       redirect_pc_o,
    output logic              slot_clr_o
);
    localparam logic [31:0] ENTRY_SET = (32'h1 << MD_BIT) | (32'h1 << RB_BIT) | (32'h1 << BL_BIT);

    typedef struct packed {
        logic [31:0]       sr;
        logic [31:0]       spc;
        logic [31:0]       ssr;
        logic [DATA_W-1:0] sgr;
        logic [11:0]       expevt;
        logic [11:0]       intevt;
        logic [TRAP_W-1:0] tra;
        logic              halt;
        logic              redir;
        logic [31:0]       redir_pc;
        logic              slot_clr;
    } ctrl_st_t;

    localparam ctrl_st_t RESET_ST = '{sr: SR_RESET, default: '0};

    ctrl_st_t          st_d, st_q;
    event_t            ev;
    logic              swap_d;
    logic              reg_we_d;
    logic [DATA_W-1:0] sp_val;

    exc_select u_select (
        .exc_req  (exc_req_i),
        .exc_tlb  (exc_tlb_i),
        .exc_code (exc_code_i),
        .trap_req (trap_req_i),
        .ill_req  (ill_req_i),
        .irq_req  (irq_req_i),
        .irq_code (irq_code_i),
        .in_slot  (in_slot_i),
        .blocked  (st_q.sr[BL_BIT]),
        .ev       (ev)
    );

    exc_bank_regs #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_ALT(NUM_ALT)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .swap    (swap_d),
        .we      (reg_we_d),
        .waddr   (reg_waddr_i),
        .wdata   (reg_wdata_i),
        .raddr   (reg_raddr_i),
        .rdata   (reg_rdata_o),
        .braddr  (alt_raddr_i),
        .bdata   (alt_rdata_o),
        .top_reg (sp_val)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redir    = 1'b0;
        st_d.slot_clr = 1'b0;
        swap_d        = 1'b0;
        reg_we_d      = 1'b0;
        if (!st_q.halt) begin
            if (ev.valid) begin
                if (ev.cls != VEC_IRQ && vbr_i == '0) begin
                    st_d.halt = 1'b1;
                end else begin
                    st_d.spc      = ev.slot_adj ? pc_i - 32'd2 : pc_i;
                    st_d.slot_clr = ev.slot_adj;
                    st_d.ssr      = st_q.sr;
                    st_d.sgr      = sp_val;
                    st_d.sr       = st_q.sr | ENTRY_SET;
                    swap_d        = !st_q.sr[RB_BIT];
                    st_d.redir    = 1'b1;
                    unique case (ev.cls)
                        VEC_TLB: st_d.redir_pc = vbr_i + TLB_OFF;
                        VEC_IRQ: st_d.redir_pc = vbr_i + IRQ_OFF;
                        default: st_d.redir_pc = vbr_i + GEN_OFF;
                    endcase
                    if (ev.cls == VEC_IRQ) st_d.intevt = ev.code;
                    else                   st_d.expevt = ev.code;
                    if (ev.is_trap) st_d.tra = {trap_imm_i, 2'b00};
                end
            end else if (sr_wr_i) begin
                st_d.sr = sr_wdata_i;
                swap_d  = sr_wdata_i[RB_BIT] ^ st_q.sr[RB_BIT];
            end else begin
                reg_we_d = reg_we_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_ST;
        else        st_q <= st_d;
    end

    assign sr_o             = st_q.sr;
    assign saved_pc_o       = st_q.spc;
    assign saved_sr_o       = st_q.ssr;
    assign saved_sp_o       = st_q.sgr;
    assign exc_event_o      = st_q.expevt;
    assign irq_event_o      = st_q.intevt;
    assign trap_val_o       = st_q.tra;
    assign halt_o           = st_q.halt;
    assign redirect_valid_o = st_q.redir;
    assign redirect_pc_o    = st_q.redir_pc;
    assign slot_clr_o       = st_q.slot_clr;

    // R1
    vector_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.redir |-> ((st_q.redir_pc - $past(vbr_i)) == GEN_OFF) ||
                       ((st_q.redir_pc - $past(vbr_i)) == TLB_OFF) ||
                       ((st_q.redir_pc - $past(vbr_i)) == IRQ_OFF));
    // R3
    entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.redir |-> ((st_q.sr & ENTRY_SET) == ENTRY_SET));
    // R5
    slot_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.slot_clr |-> st_q.redir && (st_q.spc == $past(pc_i) - 32'd2));
    // R9
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.halt |=> st_q.halt && $stable(st_q.sr) && $stable(st_q.spc) &&
                      $stable(st_q.expevt) && !st_q.redir);
    // R10
    irq_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.redir && (st_q.intevt != $past(st_q.intevt))) |-> !$past(st_q.sr[BL_BIT]));
endmodule

// File: tb/exc_entry_ctrl_bench.sv
module exc_entry_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pc_i, vbr_i, sr_wdata_i, reg_wdata_i;
    logic        in_slot_i, exc_req_i, exc_tlb_i, trap_req_i, ill_req_i, irq_req_i;
    logic        sr_wr_i, reg_we_i;
    logic [11:0] exc_code_i, irq_code_i;
    logic [7:0]  trap_imm_i;
    logic [3:0]  reg_waddr_i, reg_raddr_i;
    logic [2:0]  alt_raddr_i;
    logic [31:0] reg_rdata_o, alt_rdata_o, sr_o, saved_pc_o, saved_sr_o, saved_sp_o, redirect_pc_o;
    logic [11:0] exc_event_o, irq_event_o;
    logic [9:0]  trap_val_o;
    logic        halt_o, redirect_valid_o, slot_clr_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_ctrl u_exc_entry_ctrl (.*);

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        exc_req_i = 0; exc_tlb_i = 0; trap_req_i = 0; ill_req_i = 0; irq_req_i = 0;
        sr_wr_i = 0; reg_we_i = 0; in_slot_i = 0;
    endtask

    task automatic write_sr(input logic [31:0] v);
        sr_wr_i = 1; sr_wdata_i = v; step(); idle();
    endtask

    task automatic t_reset();
        chk("R11 sr", sr_o, 32'h7000_00F0);
        chk("R11 halt", {31'b0, halt_o}, 0);
        chk("R11 redirect", {31'b0, redirect_valid_o}, 0);
        chk("R11 exc_event", {20'b0, exc_event_o}, 0);
        reg_raddr_i = 4'd5; #1;
        chk("R11 reg", reg_rdata_o, 0);
    endtask

    task automatic t_direct_swap();
        write_sr(32'h0000_00F0);
        for (int i = 0; i < 16; i++) begin
            reg_we_i = 1; reg_waddr_i = i[3:0]; reg_wdata_i = 32'h100 + i; step();
        end
        idle();
        write_sr(32'h2000_00F0);
        reg_raddr_i = 4'd3; alt_raddr_i = 3'd3; #1;
        chk("R4 swap main", reg_rdata_o, 0);
        chk("R4 swap alt", alt_rdata_o, 32'h103);
        write_sr(32'h2000_00F1);
        #1;
        chk("R4 no swap main", reg_rdata_o, 0);
        chk("R4 no swap alt", alt_rdata_o, 32'h103);
        sr_wr_i = 1; sr_wdata_i = 32'h0000_00F0; reg_we_i = 1; reg_waddr_i = 4'd3; reg_wdata_i = 32'hDEAD;
        step(); idle(); #1;
        chk("R4 swap back / write dropped", reg_rdata_o, 32'h103);
        reg_raddr_i = 4'd8; #1;
        chk("R4 upper regs not swapped", reg_rdata_o, 32'h108);
    endtask

    task automatic t_general();
        pc_i = 32'h1000; exc_req_i = 1; exc_code_i = 12'h0E0; step(); idle();
        chk("R1 redirect", {31'b0, redirect_valid_o}, 1);
        chk("R1 vector gen", redirect_pc_o, 32'h8C00_0100);
        chk("R2 spc", saved_pc_o, 32'h1000);
        chk("R2 ssr", saved_sr_o, 32'h0000_00F0);
        chk("R2 sgr", saved_sp_o, 32'h10F);
        chk("R3 sr", sr_o, 32'h7000_00F0);
        chk("R6 exc_event", {20'b0, exc_event_o}, 12'h0E0);
        reg_raddr_i = 4'd2; alt_raddr_i = 3'd2; #1;
        chk("R4 entry swap main", reg_rdata_o, 0);
        chk("R4 entry swap alt", alt_rdata_o, 32'h102);
        step();
        chk("R1 pulse ends", {31'b0, redirect_valid_o}, 0);
        write_sr(32'h0000_00F0);
    endtask

    task automatic t_tlb_slot();
        pc_i = 32'h2002; in_slot_i = 1; exc_req_i = 1; exc_tlb_i = 1; exc_code_i = 12'h040;
        step(); idle();
        chk("R1 vector tlb", redirect_pc_o, 32'h8C00_0400);
        chk("R5 spc minus 2", saved_pc_o, 32'h2000);
        chk("R5 slot_clr", {31'b0, slot_clr_o}, 1);
        write_sr(32'h0000_00F0);
    endtask

    task automatic t_trap();
        pc_i = 32'h3000; trap_req_i = 1; trap_imm_i = 8'h21; step(); idle();
        chk("R7 trap val", {22'b0, trap_val_o}, 32'h84);
        chk("R7 trap code", {20'b0, exc_event_o}, 12'h160);
        chk("R7 trap vector", redirect_pc_o, 32'h8C00_0100);
        write_sr(32'h0000_00F0);
    endtask

    task automatic t_illegal();
        in_slot_i = 1; ill_req_i = 1; step(); idle();
        chk("R8 slot illegal", {20'b0, exc_event_o}, 12'h1A0);
        write_sr(32'h0000_00F0);
        ill_req_i = 1; step(); idle();
        chk("R8 illegal", {20'b0, exc_event_o}, 12'h180);
    endtask

    task automatic t_irq();
        irq_req_i = 1; irq_code_i = 12'h320; step(); idle();
        chk("R10 irq blocked redirect", {31'b0, redirect_valid_o}, 0);
        chk("R10 irq blocked event", {20'b0, irq_event_o}, 0);
        write_sr(32'h0000_00F0);
        pc_i = 32'h4000; in_slot_i = 1; irq_req_i = 1; irq_code_i = 12'h320; step(); idle();
        chk("R1 vector irq", redirect_pc_o, 32'h8C00_0600);
        chk("R5 irq no adjust", saved_pc_o, 32'h4000);
        chk("R6 irq_event", {20'b0, irq_event_o}, 12'h320);
        chk("R6 exc_event kept", {20'b0, exc_event_o}, 12'h180);
        write_sr(32'h0000_00F0);
    endtask

    task automatic t_priority();
        exc_req_i = 1; exc_code_i = 12'h0A0; irq_req_i = 1; irq_code_i = 12'h3C0; trap_req_i = 1;
        step(); idle();
        chk("R10 exc wins code", {20'b0, exc_event_o}, 12'h0A0);
        chk("R10 irq untouched", {20'b0, irq_event_o}, 12'h320);
        chk("R10 exc wins vector", redirect_pc_o, 32'h8C00_0100);
        write_sr(32'h0000_00F0);
    endtask

    task automatic t_halt();
        vbr_i = 0; pc_i = 32'h5000; exc_req_i = 1; exc_code_i = 12'h0E0; step(); idle();
        chk("R9 halt", {31'b0, halt_o}, 1);
        chk("R9 no redirect", {31'b0, redirect_valid_o}, 0);
        chk("R9 sr kept", sr_o, 32'h0000_00F0);
        chk("R9 exc_event kept", {20'b0, exc_event_o}, 12'h0A0);
        write_sr(32'h2000_00F0);
        chk("R9 sr frozen", sr_o, 32'h0000_00F0);
        reg_raddr_i = 4'd2; #1;
        chk("R9 regs frozen", reg_rdata_o, 32'h102);
        chk("R9 halt sticky", {31'b0, halt_o}, 1);
    endtask

    initial begin
        idle();
        rst_n = 0; pc_i = 0; vbr_i = 32'h8C00_0000; sr_wdata_i = 0; reg_wdata_i = 0;
        exc_code_i = 0; irq_code_i = 0; trap_imm_i = 0; reg_waddr_i = 0; reg_raddr_i = 0; alt_raddr_i = 0;
        step(); step();
        rst_n = 1; step();
        t_reset();
        t_direct_swap();
        t_general();
        t_tlb_slot();
        t_trap();
        t_illegal();
        t_irq();
        t_priority();
        t_halt();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule